// File: doc/BRIEF.md
# Conditional branch and call sequencer

This block walks an 8-bit processor through its control-transfer operations. A decoder hands it one request at a time: an absolute jump, a relative jump, a jump to the address held in HL, a subroutine call, or a return. Each request carries a condition code. The block tests that code against the zero and carry flags in the cycle it accepts the request. It then fetches immediate bytes and pushes or pops the return address over a byte-wide memory port. That port has separate read and write strobes and completes a transfer when `mem_ready` is high at a clock edge. The block holds the 16-bit program counter and stack pointer itself.

The timing of a condition that fails follows the taken path as far as the operands go. A jump or call whose condition fails still fetches and drops all of its immediate bytes. A return whose condition fails still performs its first stack read. A taken sequence that loads a new PC from memory is followed by one idle cycle before it finishes. `done` pulses for one cycle once the sequence has finished. The new PC and SP are visible on the outputs by then.

Top module: `ctl_flow_seq`

## Requirements
- R1: After reset, PC is 0x0100, SP is 0xFFFE, and `busy`, `done`, `mem_rd` and `mem_wr` are all low.
- R2: The condition codes are 0 = always, 1 = carry set, 2 = zero set, 3 = carry clear and 4 = zero clear. Codes 5 to 7 are never satisfied. The flags are sampled in the cycle the request is accepted.
- R3: A request is accepted only when `req_valid` is high and the block is idle. The kind codes are 0 = absolute jump, 1 = relative jump, 2 = jump to HL, 3 = call and 4 = return. Kinds 5 to 7 are ignored. A request presented while `busy` is high has no effect on PC, SP or the memory accesses.
- R4: Every immediate fetch reads the byte at PC, and PC then advances by one. An absolute jump fetches two bytes. If taken, the new PC is (second byte << 8) | first byte. If not taken, PC ends up advanced by 2.
- R5: A relative jump fetches one byte. If taken, the new PC is the PC past that byte plus the sign-extended byte. If not taken, PC is advanced by 1.
- R6: A taken absolute jump, relative jump, call or return spends exactly one busy cycle with no memory request, after the new PC is loaded. No other sequence has such a cycle.
- R7: A jump to HL copies `hl_val` into PC whatever the condition code is. It makes no memory access, never raises `busy`, and pulses `done` in the cycle after acceptance.
- R8: A taken call lowers SP by 2. It writes the low byte of PC+2 at the new SP and then the high byte at SP+1. It then fetches the target as in R4. Between clock edges SP only ever changes by exactly ±2.
- R9: A call whose condition fails makes no writes and leaves SP unchanged. It fetches and discards two bytes, so PC advances by 2.
- R10: A taken return reads the new PC low byte at SP and then the high byte at SP+1. It then adds 2 to SP.
- R11: A return whose condition fails performs one read at SP and then finishes with PC and SP unchanged.
- R12: At most one of `mem_rd` and `mem_wr` is high at a time. A request that is not yet accepted keeps its strobe, address and write data unchanged into the next cycle.
- R13: `done` is high for one cycle: the first idle cycle after a sequence ends, and never while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Operation kind code (R3) |
| req_cond | input | 3 | Condition code (R2) |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| hl_val | input | 16 | HL register value |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, taken at the completing edge |
| mem_ready | input | 1 | Transfer completes at this edge |
| pc_out | output | 16 | Program counter |
| sp_out | output | 16 | Stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a call whose target bytes overlap the stack slots it has just written, combined with long ready stalls in the middle of a push. The stall is what exercises the hold rule. The random phase sends long runs of mixed calls and returns while `mem_ready` is dropped a third of the time. The reference model overlays the pending pushes on its memory image before it predicts the fetched target. Condition outcomes are forced in both directions for every kind, and junk requests are injected in the first busy cycle. This confirms that failed conditions still cost their accesses and that busy-time requests leave no trace.

// File: rtl/cf_pkg.sv
`timescale 1ns/1ps
package cf_pkg;
    localparam int CF_CODE_W = 3;

    typedef enum logic [CF_CODE_W-1:0] {
        KIND_ABS  = 3'd0,
        KIND_REL  = 3'd1,
        KIND_IND  = 3'd2,
        KIND_CALL = 3'd3,
        KIND_RET  = 3'd4
    } cf_kind_e;

    typedef enum logic [CF_CODE_W-1:0] {
        CC_ALWAYS = 3'd0,
        CC_CARRY  = 3'd1,
        CC_ZERO   = 3'd2,
        CC_NCARRY = 3'd3,
        CC_NZERO  = 3'd4
    } cf_cc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IMM_LO,
        ST_IMM_HI,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_POP_LO,
        ST_POP_HI,
        ST_STALL
    } cf_state_e;
endpackage

// File: rtl/cf_cond_eval.sv
`timescale 1ns/1ps
module cf_cond_eval
    import cf_pkg::*;
(
    input  logic [CF_CODE_W-1:0] cc,
    input  logic                 flag_z,
    input  logic                 flag_c,
    output logic                 pass
);
    always_comb begin
        case (cc)
            CC_ALWAYS: pass = 1'b1;
            CC_CARRY:  pass = flag_c;
            CC_ZERO:   pass = flag_z;
            CC_NCARRY: pass = ~flag_c;
            CC_NZERO:  pass = ~flag_z;
            default:   pass = 1'b0;   // unused codes never pass (R2)
        endcase
    end
endmodule

// File: rtl/cf_addr_unit.sv
`timescale 1ns/1ps
module cf_addr_unit #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] sp,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] rd,
    output logic [AW-1:0] pc_p1,
    output logic [AW-1:0] pc_p2,
    output logic [AW-1:0] pc_rel,
    output logic [AW-1:0] imm_tgt,
    output logic [AW-1:0] sp_m2,
    output logic [AW-1:0] sp_p1,
    output logic [AW-1:0] sp_p2
);
    localparam int EXT_W = AW - DW;

    logic [AW-1:0] disp;

    assign disp    = {{EXT_W{rd[DW-1]}}, rd};
    assign pc_p1   = pc + AW'(1);
    assign pc_p2   = pc + AW'(2);
    // offset is applied to the PC already past the operand byte (R5)
    assign pc_rel  = pc_p1 + disp;
    assign imm_tgt = AW'({rd, lo});
    assign sp_m2   = sp - AW'(2);
    assign sp_p1   = sp + AW'(1);
    assign sp_p2   = sp + AW'(2);
endmodule

// File: rtl/cf_seq_fsm.sv
`timescale 1ns/1ps
module cf_seq_fsm
    import cf_pkg::*;
#(
    parameter int            AW     = 16,
    parameter int            DW     = 8,
    parameter logic [AW-1:0] PC_RST = 'h0100,
    parameter logic [AW-1:0] SP_RST = 'hFFFE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [CF_CODE_W-1:0] req_kind,
    input  logic                 cond_pass,
    input  logic [AW-1:0]        hl_val,
    input  logic [DW-1:0]        mem_rdata,
    input  logic                 mem_ready,
    input  logic [AW-1:0]        pc_p1,
    input  logic [AW-1:0]        pc_p2,
    input  logic [AW-1:0]        pc_rel,
    input  logic [AW-1:0]        imm_tgt,
    input  logic [AW-1:0]        sp_m2,
    input  logic [AW-1:0]        sp_p1,
    input  logic [AW-1:0]        sp_p2,
    output logic [AW-1:0]        pc_o,
    output logic [AW-1:0]        sp_o,
    output logic [DW-1:0]        lo_o,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    output logic                 busy,
    output logic                 done
);
    typedef struct packed {
        cf_state_e            st;
        logic [CF_CODE_W-1:0] kind;
        logic                 take;
        logic [AW-1:0]        pc;
        logic [AW-1:0]        sp;
        logic [DW-1:0]        lo;
        logic                 done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic xfer;

    // memory request decode from the registered state
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = seq_q.pc;
        mem_wdata = '0;
        case (seq_q.st)
            ST_IMM_LO, ST_IMM_HI: begin
                mem_rd   = 1'b1;
                mem_addr = seq_q.pc;
            end
            ST_PUSH_LO: begin
                mem_wr    = 1'b1;
                mem_addr  = seq_q.sp;
                mem_wdata = pc_p2[DW-1:0];
            end
            ST_PUSH_HI: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_p1;
                mem_wdata = DW'(pc_p2 >> DW);
            end
            ST_POP_LO: begin
                mem_rd   = 1'b1;
                mem_addr = seq_q.sp;
            end
            ST_POP_HI: begin
                mem_rd   = 1'b1;
                mem_addr = sp_p1;
            end
            default: ;
        endcase
    end

    assign xfer = (mem_rd | mem_wr) & mem_ready;

    // next-state computation
    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.kind = req_kind;
                    seq_d.take = cond_pass;
                    case (req_kind)
                        KIND_ABS, KIND_REL: seq_d.st = ST_IMM_LO;
                        KIND_IND: begin
                            seq_d.pc   = hl_val;
                            seq_d.done = 1'b1;
                        end
                        KIND_CALL: begin
                            if (cond_pass) begin
                                seq_d.sp = sp_m2;
                                seq_d.st = ST_PUSH_LO;
                            end else begin
                                seq_d.st = ST_IMM_LO;
                            end
                        end
                        KIND_RET: seq_d.st = ST_POP_LO;
                        default: ;
                    endcase
                end
            end
            ST_IMM_LO: begin
                if (xfer) begin
                    seq_d.pc = pc_p1;
                    seq_d.lo = mem_rdata;
                    if (seq_q.kind == KIND_REL) begin
                        if (seq_q.take) begin
                            seq_d.pc = pc_rel;
                            seq_d.st = ST_STALL;
                        end else begin
                            seq_d.st   = ST_IDLE;
                            seq_d.done = 1'b1;
                        end
                    end else begin
                        seq_d.st = ST_IMM_HI;
                    end
                end
            end
            ST_IMM_HI: begin
                if (xfer) begin
                    if (seq_q.take) begin
                        seq_d.pc = imm_tgt;
                        seq_d.st = ST_STALL;
                    end else begin
                        seq_d.pc   = pc_p1;
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end
                end
            end
            ST_PUSH_LO: if (xfer) seq_d.st = ST_PUSH_HI;
            ST_PUSH_HI: if (xfer) seq_d.st = ST_IMM_LO;
            ST_POP_LO: begin
                if (xfer) begin
                    seq_d.lo = mem_rdata;
                    if (seq_q.take) begin
                        seq_d.st = ST_POP_HI;
                    end else begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end
                end
            end
            ST_POP_HI: begin
                if (xfer) begin
                    seq_d.pc = imm_tgt;
                    seq_d.sp = sp_p2;
                    seq_d.st = ST_STALL;
                end
            end
            ST_STALL: begin
                seq_d.st   = ST_IDLE;
                seq_d.done = 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, kind: '0, take: 1'b0, pc: PC_RST,
                       sp: SP_RST, lo: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pc_o = seq_q.pc;
    assign sp_o = seq_q.sp;
    assign lo_o = seq_q.lo;
    assign busy = (seq_q.st != ST_IDLE);
    assign done = seq_q.done;

    assert_single_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_hold_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_ready) |=>
        ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_rd) && $stable(mem_wr)));

    assert_sp_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_o != $past(sp_o)) |->
        ((sp_o == $past(sp_o) - AW'(2)) || (sp_o == $past(sp_o) + AW'(2))));

    assert_done_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_start_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    assert_stall_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rd && !mem_wr) |=> done);
endmodule

// File: rtl/ctl_flow_seq.sv
`timescale 1ns/1ps
module ctl_flow_seq
    import cf_pkg::*;
#(
    parameter int            AW     = 16,
    parameter int            DW     = 8,
    parameter logic [AW-1:0] PC_RST = 'h0100,
    parameter logic [AW-1:0] SP_RST = 'hFFFE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [CF_CODE_W-1:0] req_kind,
    input  logic [CF_CODE_W-1:0] req_cond,
    input  logic                 flag_z,
    input  logic                 flag_c,
    input  logic [AW-1:0]        hl_val,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic [DW-1:0]        mem_rdata,
    input  logic                 mem_ready,
    output logic [AW-1:0]        pc_out,
    output logic [AW-1:0]        sp_out,
    output logic                 busy,
    output logic                 done
);
    logic          cond_pass;
    logic [DW-1:0] lo_byte;
    logic [AW-1:0] pc_p1, pc_p2, pc_rel, imm_tgt, sp_m2, sp_p1, sp_p2;

    cf_cond_eval i_cond (
        .cc     (req_cond),
        .flag_z (flag_z),
        .flag_c (flag_c),
        .pass   (cond_pass)
    );

    cf_addr_unit #(.AW(AW), .DW(DW)) i_addr (
        .pc      (pc_out),
        .sp      (sp_out),
        .lo      (lo_byte),
        .rd      (mem_rdata),
        .pc_p1   (pc_p1),
        .pc_p2   (pc_p2),
        .pc_rel  (pc_rel),
        .imm_tgt (imm_tgt),
        .sp_m2   (sp_m2),
        .sp_p1   (sp_p1),
        .sp_p2   (sp_p2)
    );

    cf_seq_fsm #(.AW(AW), .DW(DW), .PC_RST(PC_RST), .SP_RST(SP_RST)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .cond_pass (cond_pass),
        .hl_val    (hl_val),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .pc_p1     (pc_p1),
        .pc_p2     (pc_p2),
        .pc_rel    (pc_rel),
        .imm_tgt   (imm_tgt),
        .sp_m2     (sp_m2),
        .sp_p1     (sp_p1),
        .sp_p2     (sp_p2),
        .pc_o      (pc_out),
        .sp_o      (sp_out),
        .lo_o      (lo_byte),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .done      (done)
    );
endmodule

// File: tb/test_ctl_flow_seq.sv
`timescale 1ns/1ps
module test_ctl_flow_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_kind, req_cond;
    logic        flag_z, flag_c;
    logic [15:0] hl_val;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ready;
    logic [15:0] pc_out, sp_out;
    logic        busy, done;

    always #2.5 clk = ~clk;

    ctl_flow_seq i_ctl_flow_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_cond(req_cond), .flag_z(flag_z), .flag_c(flag_c), .hl_val(hl_val),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .pc_out(pc_out),
        .sp_out(sp_out), .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0]  mem [logic [15:0]];
    logic [15:0] m_pc = 16'h0100;
    logic [15:0] m_sp = 16'hFFFE;

    logic [1:0]  ek [0:7];
    logic [15:0] ea [0:7];
    logic [7:0]  ed [0:7];
    int          en;
    logic [1:0]  gk [0:7];
    logic [15:0] ga [0:7];
    logic [7:0]  gd [0:7];
    int          gn;

    function automatic logic [7:0] dflt(input logic [15:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] rd_mem(input logic [15:0] a);
        if (mem.exists(a)) return mem[a];
        return dflt(a);
    endfunction

    function automatic bit cond_ok(input int cc, input bit z, input bit c);
        case (cc)
            0: return 1'b1;
            1: return c;
            2: return z;
            3: return !c;
            4: return !z;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic add_exp(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
        if (en < 8) begin ek[en] = k; ea[en] = a; ed[en] = d; end
        en++;
    endtask

    // kind: 0 abs, 1 rel, 2 hl, 3 call, 4 ret; called at a negedge
    task automatic run_op(input int kind, input int cc, input bit z, input bit c,
                          input logic [15:0] hl, input bit junk, input bit fast);
        bit taken;
        logic [7:0] b0, b1;
        logic [15:0] e_pc, e_sp, nsp, ret;
        int e_stall, stalls, cyc;
        bit first, p_pend, p_rdy, p_rd, p_wr, rdy;
        logic [15:0] p_addr;
        logic [7:0] p_wd;
        string base;
        taken = cond_ok(cc, z, c);
        en = 0; gn = 0; e_pc = m_pc; e_sp = m_sp; e_stall = 0;
        case (kind)
            0: begin
                base = "R4 abs";
                b0 = rd_mem(m_pc); b1 = rd_mem(m_pc + 16'd1);
                add_exp(2'd1, m_pc, b0); add_exp(2'd1, m_pc + 16'd1, b1);
                e_pc = taken ? {b1, b0} : m_pc + 16'd2; e_stall = taken;
            end
            1: begin
                base = "R5 rel";
                b0 = rd_mem(m_pc); add_exp(2'd1, m_pc, b0);
                e_pc = taken ? m_pc + 16'd1 + {{8{b0[7]}}, b0} : m_pc + 16'd1;
                e_stall = taken;
            end
            2: begin
                base = "R7 hl";
                e_pc = hl;
            end
            3: begin
                if (taken) begin
                    base = "R8 call";
                    nsp = m_sp - 16'd2; ret = m_pc + 16'd2;
                    add_exp(2'd2, nsp, ret[7:0]); add_exp(2'd2, nsp + 16'd1, ret[15:8]);
                    b0 = (m_pc == nsp + 16'd1) ? ret[15:8] : (m_pc == nsp) ? ret[7:0] : rd_mem(m_pc);
                    b1 = (m_pc + 16'd1 == nsp + 16'd1) ? ret[15:8] :
                         (m_pc + 16'd1 == nsp) ? ret[7:0] : rd_mem(m_pc + 16'd1);
                    add_exp(2'd1, m_pc, b0); add_exp(2'd1, m_pc + 16'd1, b1);
                    e_pc = {b1, b0}; e_sp = nsp; e_stall = 1;
                end else begin
                    base = "R9 call-skip";
                    add_exp(2'd1, m_pc, rd_mem(m_pc)); add_exp(2'd1, m_pc + 16'd1, rd_mem(m_pc + 16'd1));
                    e_pc = m_pc + 16'd2;
                end
            end
            default: begin
                base = taken ? "R10 ret" : "R11 ret-skip";
                b0 = rd_mem(m_sp); add_exp(2'd1, m_sp, b0);
                if (taken) begin
                    b1 = rd_mem(m_sp + 16'd1); add_exp(2'd1, m_sp + 16'd1, b1);
                    e_pc = {b1, b0}; e_sp = m_sp + 16'd2; e_stall = 1;
                end
            end
        endcase
        base = $sformatf("%s R2 cond=%0d z=%0d c=%0d", base, cc, z, c);

        req_valid = 1'b1; req_kind = 3'(kind); req_cond = 3'(cc);
        flag_z = z; flag_c = c; hl_val = hl;
        @(negedge clk);
        flag_z = $urandom; flag_c = $urandom;   // flags after acceptance must not matter
        stalls = 0; cyc = 0; first = 1'b1; p_pend = 1'b0; p_rdy = 1'b0;
        p_rd = 1'b0; p_wr = 1'b0; p_addr = '0; p_wd = '0;
        while (1) begin
            req_valid = 1'b0;
            if (done) break;
            if (cyc > 300) begin
                chk(1'b0, {base, " watchdog"}, 32'(cyc), 32'd300);
                break;
            end
            if (p_pend && !p_rdy)
                chk(mem_addr == p_addr && mem_rd == p_rd && mem_wr == p_wr &&
                    (!mem_wr || mem_wdata == p_wd), "R12 hold", {mem_rd, mem_wr, mem_addr}, {p_rd, p_wr, p_addr});
            if (mem_rd && mem_wr) chk(1'b0, "R12 single", 32'd3, 32'd1);
            if (busy && !mem_rd && !mem_wr) stalls++;
            rdy = fast ? 1'b1 : (($urandom % 3) != 0);
            mem_ready = rdy;
            mem_rdata = 8'($urandom);
            if (rdy && mem_rd) begin
                mem_rdata = rd_mem(mem_addr);
                if (gn < 8) begin gk[gn] = 2'd1; ga[gn] = mem_addr; gd[gn] = mem_rdata; end
                gn++;
            end
            if (rdy && mem_wr) begin
                mem[mem_addr] = mem_wdata;
                if (gn < 8) begin gk[gn] = 2'd2; ga[gn] = mem_addr; gd[gn] = mem_wdata; end
                gn++;
            end
            p_pend = mem_rd | mem_wr; p_rdy = rdy; p_rd = mem_rd; p_wr = mem_wr;
            p_addr = mem_addr; p_wd = mem_wdata;
            if (first && junk) begin   // R3: junk while busy
                req_valid = 1'b1; req_kind = 3'($urandom % 5); req_cond = 3'd0;
                hl_val = 16'($urandom);
            end
            first = 1'b0;
            cyc++;
            @(negedge clk);
        end
        mem_ready = 1'b0;
        chk(pc_out == e_pc, {base, " pc"}, 32'(pc_out), 32'(e_pc));
        chk(sp_out == e_sp, {base, " sp"}, 32'(sp_out), 32'(e_sp));
        chk(stalls == e_stall, {base, " R6 stall"}, 32'(stalls), 32'(e_stall));
        chk(gn == en, {base, " access count"}, 32'(gn), 32'(en));
        for (int i = 0; i < en && i < 8 && i < gn; i++)
            chk(gk[i] == ek[i] && ga[i] == ea[i] && gd[i] == ed[i],
                $sformatf("%s access %0d", base, i), {6'd0, gk[i], ga[i], gd[i]}, {6'd0, ek[i], ea[i], ed[i]});
        @(negedge clk);
        chk(!done && !busy, "R13 done one cycle", {busy, done}, 2'b00);
        m_pc = e_pc; m_sp = e_sp;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_cond = '0;
        flag_z = 1'b0; flag_c = 1'b0; hl_val = '0; mem_ready = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pc_out == 16'h0100, "R1 pc", 32'(pc_out), 32'h0100);
        chk(sp_out == 16'hFFFE, "R1 sp", 32'(sp_out), 32'hFFFE);
        chk(!busy && !done && !mem_rd && !mem_wr, "R1 idle",
            {busy, done, mem_rd, mem_wr}, 4'b0000);

        // R3: unused kind code is ignored
        req_valid = 1'b1; req_kind = 3'd5; req_cond = 3'd0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_wr && pc_out == 16'h0100 && sp_out == 16'hFFFE,
            "R3 unused kind", {busy, done, pc_out}, {2'b00, 16'h0100});

        // directed corners
        run_op(2, 3, 1'b0, 1'b1, 16'h2000, 1'b0, 1'b1);   // R7 hl, condition ignored
        mem[16'h2000] = 8'h80;
        run_op(1, 0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1);      // R5 -128
        run_op(2, 0, 1'b0, 1'b0, 16'h3000, 1'b0, 1'b0);
        mem[16'h3000] = 8'h7F;
        run_op(1, 2, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0);      // R5 +127
        run_op(2, 0, 1'b0, 1'b0, 16'h3000, 1'b0, 1'b1);
        run_op(1, 4, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0);      // R5 not taken
        run_op(2, 0, 1'b0, 1'b0, 16'h4000, 1'b0, 1'b1);
        mem[16'h4000] = 8'h34; mem[16'h4001] = 8'h12;
        run_op(3, 0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);      // R8 call to 0x1234
        chk(mem[16'hFFFC] == 8'h02 && mem[16'hFFFD] == 8'h40, "R8 stacked return",
            {mem[16'hFFFD], mem[16'hFFFC]}, 16'h4002);
        run_op(4, 2, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0);      // R11 ret not taken
        run_op(4, 1, 1'b0, 1'b1, 16'h0, 1'b1, 1'b0);      // R10 ret back
        chk(pc_out == 16'h4002 && sp_out == 16'hFFFE, "R10 return point",
            {pc_out, sp_out}, {16'h4002, 16'hFFFE});
        run_op(3, 4, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0);      // R9 call skipped
        run_op(0, 1, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);      // R4 not taken
        run_op(0, 3, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0);      // R4 taken
        run_op(0, 6, 1'b1, 1'b1, 16'h0, 1'b0, 1'b1);      // R2 unused code never passes

        for (int n = 0; n < 400; n++)
            run_op(int'($urandom % 5), int'($urandom % 6), 1'($urandom), 1'($urandom),
                   16'($urandom), 1'($urandom), ($urandom % 4) == 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule